// File: doc/BRIEF.md
# Chained Serial DAC Frame Master

This block drives a string of serial DACs that share one serial clock and one chip-select/load line. The first converter's data input takes the serial data output, and each converter passes bits on to the next. Per device, the host supplies an active flag, a 4-bit command and a 16-bit data value, and then pulses `start`. The block assembles one long frame from these. The word for the highest-numbered device goes first, because the first word shifted in travels to the far end of the chain. Any device whose active flag is clear receives the no-operation command.

During a frame the chip-select/load line is held low and every frame bit is shifted out MSB first. The line is then raised with the clock low, so all converters act on their commands on the same edge. A programmable divider sets the serial clock. The `busy` and `done` outputs tell the host when a new frame may be issued.

Top module: `dac_chain_master`

## Requirements
- R1: Each device word is 24 bits sent MSB first: command in bits 23:20, zeros in bits 19:16, the data value in bits 15:0.
- R2: Within a frame, device N_DEV-1's word is sent first and device 0's word is sent last.
- R3: A device whose `dev_active` bit is 0 receives command 4'b1111 with its data field all zeros.
- R4: `cs_ld` falls while `sck` is low, before the first rising edge. It rises only after the last rising edge of the frame, with `sck` low. `busy` is high throughout the time `cs_ld` is low.
- R5: Each frame has exactly N_DEV*24 rising edges of `sck` while `cs_ld` is low.
- R6: `sdi` never changes on a rising edge of `sck` or while `sck` is high. It changes only after falling edges, so it is stable when the converter samples it.
- R7: `sck` is high for `div_half` clock cycles and then low for `div_half` cycles, with a value of 0 treated as 1. The value is captured at `start`. `sck` stays low while `cs_ld` is high.
- R8: After `cs_ld` rises, `busy` stays high for exactly 2×half-period cycles. `busy` then falls in the same cycle as a one-cycle `done` pulse.
- R9: A `start` pulse while `busy` is high is ignored. It does not alter the frame in progress, and no further frame follows.
- R10: During and after reset, `cs_ld` is high and `sck`, `sdi`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, taken only while not busy |
| dev_active | input | N_DEV | Per-device flag, 0 selects no-operation |
| dev_cmd | input | 4*N_DEV | Per-device command, device k in bits 4k+3:4k |
| dev_data | input | 16*N_DEV | Per-device data, device k in bits 16k+15:16k |
| div_half | input | DIV_W | System clocks per serial clock half period |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| sck | output | 1 | Shared serial clock |
| cs_ld | output | 1 | Shared chip-select/load, active low |
| sdi | output | 1 | Serial data into the first device |

## Verification
The assertions assume a frame begins only from the idle state reached after reset. They also assume that `rst_n` is not asserted in the middle of a frame, so the count of rising edges always restarts at a falling edge of `cs_ld`. The stimulus changes inputs only on falling system-clock edges and makes each `start` pulse one cycle long. The per-device inputs and `div_half` change during a frame only in the ignored-start case. That case is exactly where the latched frame and the latched divider must shield the output from the change.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
   localparam int unsigned CMD_W  = 4;
   localparam int unsigned PAD_W  = 4;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned WORD_W = CMD_W + PAD_W + DATA_W;
   localparam logic [CMD_W-1:0] CMD_NOP = 4'b1111;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_HIGH,
      PH_LOW,
      PH_TAIL,
      PH_GAP
   } phase_e;
endpackage

// File: rtl/dcm_word_pack.sv
module dcm_word_pack
   import dcm_pkg::*;
#(
   parameter int unsigned N_DEV = 3
) (
   input  logic [N_DEV-1:0]        dev_active,
   input  logic [N_DEV*CMD_W-1:0]  dev_cmd,
   input  logic [N_DEV*DATA_W-1:0] dev_data,
   output logic [N_DEV*WORD_W-1:0] frame
);
   // The top slice of the frame leaves first, so it belongs to the far device.
   for (genvar g = 0; g < N_DEV; g++) begin : g_slot
      assign frame[g*WORD_W +: WORD_W] = dev_active[g]
         ? {dev_cmd[g*CMD_W +: CMD_W], {PAD_W{1'b0}}, dev_data[g*DATA_W +: DATA_W]}
         : {CMD_NOP, {PAD_W{1'b0}}, {DATA_W{1'b0}}};
   end
endmodule

// File: rtl/dcm_half_timer.sv
module dcm_half_timer #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [DIV_W-1:0] half_in,
   output logic             tick
);
   logic [DIV_W-1:0] span_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] span_d;

   assign span_d = (half_in == '0) ? DIV_W'(1) : half_in;
   assign tick   = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         span_q <= DIV_W'(1);
         cnt_q  <= '0;
      end else if (reload) begin
         span_q <= span_d;
         cnt_q  <= span_d - DIV_W'(1);
      end else if (cnt_q == '0) begin
         cnt_q  <= span_q - DIV_W'(1);
      end else begin
         cnt_q  <= cnt_q - DIV_W'(1);
      end
   end
endmodule

// File: rtl/dcm_shift_engine.sv
module dcm_shift_engine
   import dcm_pkg::*;
#(
   parameter int unsigned N_DEV = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    tick,
   input  logic [N_DEV*WORD_W-1:0] frame_in,
   output logic                    reload,
   output logic                    sck,
   output logic                    cs_ld,
   output logic                    sdi,
   output logic                    busy,
   output logic                    done
);
   localparam int unsigned TOTAL = N_DEV * WORD_W;
   localparam int unsigned CNT_W = $clog2(TOTAL);

   phase_e           phase_q;
   logic [TOTAL-1:0] sreg_q;
   logic [CNT_W-1:0] bit_q;
   logic             gap_q;
   logic             sck_q;
   logic             cs_q;
   logic             done_q;

   assign reload = (phase_q == PH_IDLE) && start;
   assign busy   = (phase_q != PH_IDLE);
   assign sck    = sck_q;
   assign cs_ld  = cs_q;
   assign done   = done_q;
   assign sdi    = !cs_q && sreg_q[TOTAL-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sreg_q  <= '0;
         bit_q   <= '0;
         gap_q   <= 1'b0;
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (start) begin
               sreg_q  <= frame_in;
               bit_q   <= '0;
               cs_q    <= 1'b0;
               phase_q <= PH_LEAD;
            end
            PH_LEAD: if (tick) begin
               sck_q   <= 1'b1;
               phase_q <= PH_HIGH;
            end
            PH_HIGH: if (tick) begin
               sck_q <= 1'b0;
               if (bit_q == CNT_W'(TOTAL-1)) begin
                  phase_q <= PH_TAIL;
               end else begin
                  sreg_q  <= {sreg_q[TOTAL-2:0], 1'b0};
                  bit_q   <= bit_q + CNT_W'(1);
                  phase_q <= PH_LOW;
               end
            end
            PH_LOW: if (tick) begin
               sck_q   <= 1'b1;
               phase_q <= PH_HIGH;
            end
            PH_TAIL: if (tick) begin
               cs_q    <= 1'b1;
               gap_q   <= 1'b0;
               phase_q <= PH_GAP;
            end
            PH_GAP: if (tick) begin
               if (gap_q) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  gap_q <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
   import dcm_pkg::*;
#(
   parameter int unsigned N_DEV = 3,
   parameter int unsigned DIV_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [N_DEV-1:0]        dev_active,
   input  logic [N_DEV*CMD_W-1:0]  dev_cmd,
   input  logic [N_DEV*DATA_W-1:0] dev_data,
   input  logic [DIV_W-1:0]        div_half,
   output logic                    busy,
   output logic                    done,
   output logic                    sck,
   output logic                    cs_ld,
   output logic                    sdi
);
   localparam int unsigned FRAME_W = N_DEV * WORD_W;

   if (N_DEV < 1) begin : g_bad_chain
      $error("dac_chain_master: N_DEV must be at least 1");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("dac_chain_master: DIV_W must lie in 1..16");
   end

   logic [FRAME_W-1:0] frame;
   logic               tick;
   logic               reload;

   dcm_word_pack #(.N_DEV(N_DEV)) u_pack (
      .dev_active (dev_active),
      .dev_cmd    (dev_cmd),
      .dev_data   (dev_data),
      .frame      (frame)
   );

   dcm_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (reload),
      .half_in (div_half),
      .tick    (tick)
   );

   dcm_shift_engine #(.N_DEV(N_DEV)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tick     (tick),
      .frame_in (frame),
      .reload   (reload),
      .sck      (sck),
      .cs_ld    (cs_ld),
      .sdi      (sdi),
      .busy     (busy),
      .done     (done)
   );
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker
   import dcm_pkg::*;
#(
   parameter int unsigned N_DEV = 3
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic sck,
   input logic cs_ld,
   input logic sdi
);
   localparam int unsigned TOTAL = N_DEV * WORD_W;
   localparam int unsigned RW    = $clog2(TOTAL + 1) + 1;

   logic [RW-1:0] rises_q;
   logic          sck_p;
   logic          cs_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rises_q <= '0;
         sck_p   <= 1'b0;
         cs_p    <= 1'b1;
      end else begin
         sck_p <= sck;
         cs_p  <= cs_ld;
         if (!cs_ld && cs_p)      rises_q <= '0;
         else if (sck && !sck_p)  rises_q <= rises_q + RW'(1);
      end
   end

   AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_ld) |-> (rises_q == RW'(TOTAL))); // R5
   AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_ld |-> !sck); // R7
   AST_SDI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(sdi)); // R6
   AST_SDI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sdi)); // R6
   AST_BUSY_SPANS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_ld |-> busy); // R4
   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && cs_ld)); // R8
   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !$fell(cs_ld)); // R9
endmodule

bind dac_chain_master dcm_checker #(.N_DEV(N_DEV)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .sck   (sck),
   .cs_ld (cs_ld),
   .sdi   (sdi)
);

// File: tb/sim_dac_chain_master.sv
module sim_dac_chain_master;
   localparam int N     = 3;
   localparam int DIV_W = 8;
   localparam int TOT   = N * 24;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [N-1:0]     dev_active = '0;
   logic [N*4-1:0]   dev_cmd = '0;
   logic [N*16-1:0]  dev_data = '0;
   logic [DIV_W-1:0] div_half = 8'd1;
   logic busy, done, sck, cs_ld, sdi;

   int checks = 0;
   int errors = 0;
   int cur_h  = 1;
   int cs_falls = 0;
   bit exp_q[$];

   always #10 clk = ~clk;

   dac_chain_master #(.N_DEV(N), .DIV_W(DIV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_active(dev_active),
      .dev_cmd(dev_cmd), .dev_data(dev_data), .div_half(div_half),
      .busy(busy), .done(done), .sck(sck), .cs_ld(cs_ld), .sdi(sdi)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: expected bit stream, far device first (R1 R2 R3).
   task automatic push_frame(input logic [N-1:0] act, input logic [N*4-1:0] cmd,
                             input logic [N*16-1:0] dat);
      for (int d = N - 1; d >= 0; d--) begin
         logic [23:0] w;
         w = act[d] ? {cmd[d*4 +: 4], 4'h0, dat[d*16 +: 16]} : {4'hF, 20'h0};
         for (int b = 23; b >= 0; b--) exp_q.push_back(w[b]);
      end
   endtask

   task automatic launch(input logic [N-1:0] act, input logic [N*4-1:0] cmd,
                         input logic [N*16-1:0] dat, input int half);
      @(negedge clk);
      push_frame(act, cmd, dat);
      cur_h      = (half == 0) ? 1 : half;
      dev_active = act;
      dev_cmd    = cmd;
      dev_data   = dat;
      div_half   = DIV_W'(half);
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
   endtask

   task automatic wait_done();
      while (done !== 1'b1) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R5 bits left in queue", exp_q.size(), 0);
   endtask

   // Monitor: samples on the falling system-clock edge.
   bit sck_p = 0, cs_p = 1, busy_p = 0, done_p = 0, in_gap = 0;
   int rises = 0, high_len = 0, low_len = 0, gap = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sck && !sck_p) begin
            if (exp_q.size() == 0) check(0, "R5 extra sck rise", 1, 0);
            else begin
               bit e;
               e = exp_q.pop_front();
               check(sdi == e, "R1 R2 R3 sdi bit", sdi, e);
            end
            if (rises > 0) check(low_len == cur_h, "R7 low half", low_len, cur_h);
            rises++;
            high_len = 1;
         end else if (sck) high_len++;
         if (!sck && sck_p) begin
            check(high_len == cur_h, "R7 high half", high_len, cur_h);
            low_len = 1;
         end else if (!sck) low_len++;
         if (!cs_ld && cs_p) begin
            cs_falls++;
            rises = 0;
            check(sck == 0, "R4 sck low at cs fall", sck, 0);
         end
         if (cs_ld && !cs_p) begin
            check(rises == TOT, "R5 rise count", rises, TOT);
            check(sck == 0, "R4 sck low at cs rise", sck, 0);
            in_gap = 1;
            gap = 1;
         end else if (in_gap && busy) gap++;
         if (!busy && busy_p) begin
            check(gap == 2 * cur_h, "R8 gap length", gap, 2 * cur_h);
            check(done == 1'b1, "R8 done with busy fall", done, 1);
            in_gap = 0;
         end
         if (done && done_p) check(0, "R8 done wider than one cycle", 1, 0);
         sck_p = sck; cs_p = cs_ld; busy_p = busy; done_p = done;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(cs_ld == 1'b1, "R10 cs_ld in reset", cs_ld, 1);
      check(sck == 1'b0, "R10 sck in reset", sck, 0);
      check(sdi == 1'b0, "R10 sdi in reset", sdi, 0);
      check(busy == 1'b0, "R10 busy in reset", busy, 0);
      check(done == 1'b0, "R10 done in reset", done, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(cs_ld == 1'b1 && sck == 1'b0 && !busy, "R10 idle after reset", {cs_ld, sck, busy}, 3'b100);

      // All devices addressed, half period 2.
      launch(3'b111, {4'h3, 4'hA, 4'h5}, {16'hBEEF, 16'h1234, 16'h8001}, 2);
      wait_done();
      // One device addressed, zero divider taken as one (R3 R7).
      launch(3'b010, {4'h1, 4'h6, 4'h2}, {16'hFFFF, 16'hC35A, 16'h7777}, 0);
      wait_done();
      // All idle, half period 3 (R3).
      launch(3'b000, {4'h2, 4'h2, 4'h2}, {16'h5555, 16'h5555, 16'h5555}, 3);
      wait_done();
      check(sck == 1'b0 && cs_ld == 1'b1, "R7 parked between frames", {sck, cs_ld}, 2'b01);

      // Start during busy must be ignored (R9).
      launch(3'b101, {4'h9, 4'h0, 4'hC}, {16'h0F0F, 16'hAAAA, 16'h00FF}, 2);
      repeat (60) @(negedge clk);
      dev_active = 3'b111;
      dev_cmd    = 12'h000;
      dev_data   = '1;
      div_half   = 8'd5;
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
      wait_done();
      repeat (12) @(negedge clk);
      check(cs_ld == 1'b1 && !busy, "R9 no frame after ignored start", {cs_ld, busy}, 2'b10);
      check(cs_falls == 4, "R9 frame count", cs_falls, 4);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule